// File: doc/BRIEF.md
# Serial Clock-Calendar Register Slave

This block is the device side of a serial real-time clock. It listens on a four-wire serial port in clock-idles-high, sample-on-rising-edge mode, most significant bit first, with an active-high chip enable. Behind the port sits a byte-wide register file. It holds seven timekeeping bytes, two alarm sets of four bytes each, a control byte, a status byte, a charger setting byte and a bank of user RAM. The oscillator, the counting of seconds, the alarm outputs and the charger itself are not part of this block. It only stores the bytes and serves them over the serial port.

Each chip-enable window starts with an address byte. Its top bit chooses the direction: 1 means write and 0 means read. Every byte after it goes to or comes from the next address, so one window can stream a run of registers. The serial pins are oversampled in the system clock domain. A bit in the control byte locks the time and alarm bytes against writes. Whether the lock applies is fixed when a window opens, so releasing the lock only takes effect from the next window.

Top module: `spirtc_slave`

## Requirements
- R1: After reset every implemented byte reads as 0x00, the lock is off, and the serial output is 0.
- R2: The first byte of a window is an address byte. When its bit 7 is 1 the following bytes are written starting at address bits 6:0. When bit 7 is 0 the following bytes are read from there, and the bytes shifted in during a read change nothing.
- R3: After each data byte the address advances by one within the window. Raising chip enable again restarts with a new address byte.
- R4: Bits move most significant first. The input is sampled on the rising edge of the serial clock. The output changes only after a falling edge and is stable at the next rising edge.
- R5: While bit 6 of the control byte (address 0x0F) is 1, writes to addresses 0x00 to 0x0E are dropped. Control (0x0F), status (0x10), charger setting (0x11) and RAM (0x20 to 0x3F) stay writable.
- R6: The lock is sampled when chip enable rises. Clearing bit 6 inside a window does not unlock the later bytes of that same window. The next window is unlocked.
- R7: Addresses 0x12 to 0x1F and 0x40 to 0x7F read as 0x00, and writes to them are dropped.
- R8: The serial output is 0 whenever the block is not in the data phase of a read. This covers address bytes, write bytes, and any time chip enable is low.
- R9: The address wraps from 0x7F to 0x00 during a burst.
- R10: If chip enable falls in the middle of a byte, that byte is discarded and no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the serial pins are oversampled with it |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock, idles high |
| spi_ce | input | 1 | Chip enable, active high, frames one access |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |

## Verification
The bench goes after the lock timing. A long write burst clears the lock in its first byte and then wraps around into address 0x00. A design that checked the lock per byte would overwrite the seconds byte, and one that stopped the address at 0x7F would write nothing there at all. Reads that start at 0x7F catch a missing wrap. Reads across the gap above the charger byte and above the RAM catch aliasing that returns stale data. A read whose output changed on the rising edge would deliver every byte shifted by one bit. A window cut after four bits catches a design that commits partial bytes. The output is checked at every bit of address and write bytes, so a stray drive there is caught as well.

// File: rtl/spirtc_pkg.sv
`timescale 1ns/1ps
package spirtc_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int DIR_BIT = 7;
  localparam int WP_BIT = 6;

  localparam logic [ADDR_W-1:0] LAST_PROT    = 7'h0E;
  localparam logic [ADDR_W-1:0] CTRL_ADDR    = 7'h0F;
  localparam logic [ADDR_W-1:0] LAST_CLK_REG = 7'h11;
  localparam logic [ADDR_W-1:0] RAM_BASE     = 7'h20;

  typedef enum logic [1:0] {
    PH_ADDR  = 2'd0,
    PH_WRITE = 2'd1,
    PH_READ  = 2'd2
  } phase_e;

  // time and alarm bytes fall under the write lock
  function automatic logic is_locked_addr(input logic [ADDR_W-1:0] a);
    return a <= LAST_PROT;
  endfunction
endpackage

// File: rtl/spirtc_sync.sv
`timescale 1ns/1ps
module spirtc_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] q;
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q <= RESET_VAL;
        else        q <= d_async;
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q <= RESET_VAL;
        else        q <= g_stage[g-1].q;
    end
  end

  assign d_sync = g_stage[STAGES-1].q;
endmodule

// File: rtl/spirtc_shifter.sv
`timescale 1ns/1ps
module spirtc_shifter
  import spirtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_s,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              mosi_s,
  input  logic              tx_load,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_en,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              miso
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] rx_sr;
  logic [BYTE_W-1:0] tx_sr;

  // the byte completes on the rising edge carrying its last bit
  assign rx_byte   = {rx_sr, mosi_s};
  assign byte_done = ce_s && sck_rise && (bit_cnt == CNT_W'(BYTE_W-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
      miso    <= 1'b0;
    end else if (!ce_s) begin
      bit_cnt <= '0;
      tx_sr   <= '0;
      miso    <= 1'b0;
    end else begin
      if (sck_rise) begin
        rx_sr   <= rx_byte[BYTE_W-2:0];
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (sck_fall)
        miso <= tx_en ? tx_sr[BYTE_W-1] : 1'b0;
      if (tx_load)
        tx_sr <= tx_byte;
      else if (sck_fall && tx_en)
        tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spirtc_regfile.sv
`timescale 1ns/1ps
module spirtc_regfile
  import spirtc_pkg::*;
#(
  parameter int RAM_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              wp_lock,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              wr_en,
  output logic              wp_now
);
  localparam int CLK_REGS = int'(LAST_CLK_REG) + 1;
  localparam int SLOTS    = CLK_REGS + RAM_BYTES;
  localparam int SLOT_W   = $clog2(SLOTS);

  logic [BYTE_W-1:0] mem_q [SLOTS];

  function automatic logic slot_hit(input logic [ADDR_W-1:0] a);
    return (a <= LAST_CLK_REG) ||
           (a >= RAM_BASE && int'(a) < int'(RAM_BASE) + RAM_BYTES);
  endfunction

  function automatic logic [SLOT_W-1:0] slot_of(input logic [ADDR_W-1:0] a);
    if (a <= LAST_CLK_REG) return SLOT_W'(a);
    return SLOT_W'(int'(a) - int'(RAM_BASE) + CLK_REGS);
  endfunction

  assign wr_en   = wr_req && slot_hit(wr_addr) &&
                   !(wp_lock && is_locked_addr(wr_addr));
  assign rd_data = slot_hit(rd_addr) ? mem_q[slot_of(rd_addr)] : '0;
  assign wp_now  = mem_q[int'(CTRL_ADDR)][WP_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SLOTS; s++) mem_q[s] <= '0;
    end else if (wr_en) begin
      mem_q[slot_of(wr_addr)] <= wr_data;
    end
  end
endmodule

// File: rtl/spirtc_slave.sv
`timescale 1ns/1ps
module spirtc_slave
  import spirtc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RAM_BYTES   = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_ce,
  input  logic spi_mosi,
  output logic spi_miso
);
  logic [2:0] pins_s;
  logic       sck_s, ce_s, mosi_s, sck_prev, sck_rise, sck_fall;
  logic              byte_done, tx_load, tx_en, wr_req, wr_en, wp_now, wp_lock;
  logic [BYTE_W-1:0] rx_byte, rd_data;
  logic [ADDR_W-1:0] ptr, rd_addr;
  phase_e            phase;

  // sck resets high (idle level) so no false edge leaves reset
  spirtc_sync #(.W(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_async({spi_sck, spi_ce, spi_mosi}),
    .d_sync(pins_s)
  );
  assign sck_s  = pins_s[2];
  assign ce_s   = pins_s[1];
  assign mosi_s = pins_s[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sck_prev <= 1'b1;
    else        sck_prev <= sck_s;

  assign sck_rise = sck_s && !sck_prev;
  assign sck_fall = !sck_s && sck_prev;

  // window sequencing: address byte, then data bytes with increment
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_ADDR;
      ptr     <= '0;
      wp_lock <= 1'b0;
    end else if (!ce_s) begin
      phase   <= PH_ADDR;
      wp_lock <= wp_now;
    end else if (byte_done) begin
      if (phase == PH_ADDR) begin
        ptr   <= rx_byte[ADDR_W-1:0];
        phase <= rx_byte[DIR_BIT] ? PH_WRITE : PH_READ;
      end else begin
        ptr <= ptr + 1'b1;
      end
    end
  end

  assign wr_req  = byte_done && (phase == PH_WRITE);
  assign tx_en   = (phase == PH_READ);
  assign tx_load = byte_done &&
                   (((phase == PH_ADDR) && !rx_byte[DIR_BIT]) || (phase == PH_READ));
  assign rd_addr = (phase == PH_ADDR) ? rx_byte[ADDR_W-1:0] : ptr + 1'b1;

  spirtc_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .ce_s(ce_s),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s),
    .tx_load(tx_load), .tx_byte(rd_data), .tx_en(tx_en),
    .byte_done(byte_done), .rx_byte(rx_byte), .miso(spi_miso)
  );

  spirtc_regfile #(.RAM_BYTES(RAM_BYTES)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_req(wr_req), .wr_addr(ptr), .wr_data(rx_byte), .wp_lock(wp_lock),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en), .wp_now(wp_now)
  );
endmodule

// File: rtl/spirtc_slave_chk.sv
`timescale 1ns/1ps
module spirtc_slave_chk
  import spirtc_pkg::*;
#(
  parameter int RAM_BYTES = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_s,
  input logic              sck_fall,
  input logic              spi_miso,
  input logic              byte_done,
  input phase_e            phase,
  input logic [ADDR_W-1:0] ptr,
  input logic              wr_req,
  input logic              wr_en,
  input logic              wp_lock
);
  // R8
  miso_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_s |=> !spi_miso);

  // R4
  miso_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_miso) |-> ($past(sck_fall) || !$past(ce_s)));

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && phase != PH_ADDR) |=> ptr == $past(ptr) + 7'd1);

  // R3
  window_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_s |=> phase == PH_ADDR);

  // R5
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wp_lock && ptr <= LAST_PROT) |-> !wr_en);

  // R6
  wp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ce_s) |-> $stable(wp_lock));

  // R7
  wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (ptr <= LAST_CLK_REG ||
               (ptr >= RAM_BASE && int'(ptr) < int'(RAM_BASE) + RAM_BYTES)));
endmodule

bind spirtc_slave spirtc_slave_chk #(.RAM_BYTES(RAM_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_s(ce_s), .sck_fall(sck_fall),
  .spi_miso(spi_miso), .byte_done(byte_done), .phase(phase), .ptr(ptr),
  .wr_req(wr_req), .wr_en(wr_en), .wp_lock(wp_lock)
);

// File: tb/spirtc_slave_tb.sv
`timescale 1ns/1ps
module spirtc_slave_tb;
  localparam int HALF = 8;  // system clocks per serial half period

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b1, ce = 1'b0, mosi = 1'b0;
  logic miso;

  always #4 clk = ~clk;  // 125 MHz

  spirtc_slave u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_ce(ce),
    .spi_mosi(mosi), .spi_miso(miso)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] mdl  [0:127];
  logic [7:0] wbuf [0:127];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] got_byte;
  event       got_ev;

  function automatic bit impl(int a);
    return (a <= 'h11) || (a >= 'h20 && a <= 'h3F);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, input bit quiet,
                      input string tag, output logic [7:0] rx);
    rx = '0;
    for (int b = 0; b < nbits; b++) begin
      sck = 1'b0;
      mosi = tx[7-b];
      wait_clk(HALF);
      rx[7-b] = miso;
      if (quiet) check(miso == 1'b0, {tag, " R8 quiet output"}, miso, 0);
      sck = 1'b1;
      wait_clk(HALF);
    end
  endtask

  task automatic ce_open();
    ce = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic ce_close();
    wait_clk(HALF);
    ce = 1'b0;
    wait_clk(2 * HALF);
    check(miso == 1'b0, "R8 idle after window", miso, 0);
  endtask

  task automatic wr_burst(input int a, input int n, input string tag);
    logic [7:0] rx;
    bit lock;
    lock = mdl[15][6];
    ce_open();
    xfer(8'h80 | 8'(a), 8, 1'b1, tag, rx);
    for (int i = 0; i < n; i++) begin
      int ad;
      ad = (a + i) & 'h7F;
      xfer(wbuf[i], 8, 1'b1, tag, rx);
      if (impl(ad) && !(lock && ad <= 'h0E)) mdl[ad] = wbuf[i];
    end
    ce_close();
  endtask

  task automatic rd_burst(input int a, input int n, input string tag);
    logic [7:0] rx;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(mdl[(a + i) & 'h7F]);
      tag_q.push_back(tag);
    end
    ce_open();
    xfer(8'(a) & 8'h7F, 8, 1'b1, tag, rx);
    for (int i = 0; i < n; i++) begin
      xfer(8'hA5, 8, 1'b0, tag, rx);
      got_byte = rx;
      ->got_ev;
    end
    ce_close();
  endtask

  // monitor: compares produced bytes against the scoreboard queue
  initial begin
    logic [7:0] e;
    string t;
    forever begin
      @(got_ev);
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected byte", got_byte, 0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(got_byte == e, t, got_byte, e);
      end
    end
  end

  initial begin
    #1_200_000;
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    for (int i = 0; i < 128; i++) mdl[i] = 8'h00;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R1: reset state
    check(miso == 1'b0, "R1 output after reset", miso, 0);
    rd_burst('h00, 18, "R1 reset contents");

    // R2 R3: time burst write and read back, hour in 12h PM form
    wbuf[0] = 8'h59; wbuf[1] = 8'h30; wbuf[2] = 8'h72; wbuf[3] = 8'h03;
    wbuf[4] = 8'h31; wbuf[5] = 8'h12; wbuf[6] = 8'h99;
    wr_burst('h00, 7, "R2 time write");
    rd_burst('h00, 7, "R3 time burst read");
    rd_burst('h02, 1, "R2 single read");
    rd_burst('h00, 3, "R2 read leaves data intact");

    // R4: asymmetric patterns catch bit order and edge errors
    wbuf[0] = 8'h01; wbuf[1] = 8'h80; wbuf[2] = 8'h02; wbuf[3] = 8'h40;
    wbuf[4] = 8'h04; wbuf[5] = 8'h20; wbuf[6] = 8'h08; wbuf[7] = 8'h10;
    wr_burst('h07, 8, "R4 alarm write");
    rd_burst('h07, 8, "R4 alarm bit order");
    wbuf[0] = 8'h80; wbuf[1] = 8'h01; wbuf[2] = 8'hC3; wbuf[3] = 8'h3C;
    wr_burst('h20, 4, "R4 ram write");
    rd_burst('h20, 4, "R4 ram bit order");

    // R5: lock on, protected writes dropped, others land
    wbuf[0] = 8'h40; wr_burst('h0F, 1, "R5 set lock");
    wbuf[0] = 8'h11; wr_burst('h00, 1, "R5 locked seconds");
    wbuf[0] = 8'hFF; wr_burst('h09, 1, "R5 locked alarm");
    wbuf[0] = 8'hA5; wbuf[1] = 8'h5A; wr_burst('h10, 2, "R5 status charger");
    wbuf[0] = 8'h7E; wr_burst('h3F, 1, "R5 ram last");
    rd_burst('h00, 18, "R5 lock effect");
    rd_burst('h3F, 1, "R5 ram under lock");

    // R6 R9: clear lock then wrap to 0x00 within the same window
    wbuf[0] = 8'h00;
    for (int i = 1; i < 114; i++) wbuf[i] = 8'(((('h0F + i) & 'h7F)) ^ 'hC6);
    wr_burst('h0F, 114, "R6 unlock burst");
    rd_burst('h0F, 3, "R6 control status charger");
    rd_burst('h00, 1, "R6 seconds still locked");
    wbuf[0] = 8'h11; wr_burst('h00, 1, "R6 next window");
    rd_burst('h00, 1, "R6 seconds unlocked");

    // R7: unimplemented gaps read zero
    rd_burst('h12, 14, "R7 gap above charger");
    rd_burst('h3E, 5, "R7 ram end and above");

    // R9: read wrap
    rd_burst('h7F, 2, "R9 read wrap");

    // R10: window cut mid byte
    ce_open();
    xfer(8'hA1, 8, 1'b1, "R10 addr", rx);
    xfer(8'hFF, 4, 1'b1, "R10 partial", rx);
    ce_close();
    rd_burst('h21, 1, "R10 partial byte dropped");

    wait_clk(10);
    check(exp_q.size() == 0, "R3 all read bytes seen", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule